// File: doc/BRIEF.md
# Bus-Mapped Display Control Peripheral

This peripheral sits on a shared fetch/store bus and gives a processor control of a display through three 4-byte words in a 12-byte address window. The window starts at a base address set by a parameter. One word switches the display on or off. One sets a 4-bit brightness level. One drives sixteen separate status lights. The peripheral sees every bus request. It acts only on selected requests whose address falls inside its window and ignores all other requests.

The three words are laid out in order from the base. Bytes 0..3 are the power word, bytes 4..7 are the brightness word and bytes 8..11 are the light word. Any byte address within a word reaches that word. A selected request inside the window is acknowledged on the next cycle. A fetch places its result on the read data in that same acknowledge cycle. Only the power word returns state when read. The other two words read as zero.

Top module: `disp_ctl_periph`

## Requirements
- R1: After reset the display is off, brightness is 0, all sixteen lights are off, the acknowledge is low and the read data is zero.
- R2: A store to any byte address of the power word (window offsets 0..3) turns the display on when the full stored value is nonzero, and turns it off when the value is zero.
- R3: A fetch from the power word returns exactly 1 while the display is on and 0 while it is off.
- R4: A store to the brightness word (offsets 4..7) loads the brightness from bits 3:0 of the stored value. The higher bits are ignored.
- R5: A store to the light word (offsets 8..11) sets light i from bit i of the stored value, for i = 0..15, with 1 meaning on. Bits 31:16 are ignored.
- R6: A fetch from the brightness word or the light word returns zero and is still acknowledged.
- R7: The acknowledge is high in exactly the cycle after a selected in-window fetch or store, and low otherwise. The read data is zero whenever the acknowledge is low.
- R8: A request with select low, or with an address outside the 12-byte window (below the base, or at base+12 and above), gives no acknowledge and leaves power, brightness and lights unchanged.
- R9: A fetch never changes power, brightness or lights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Bus request valid for this cycle |
| store_i | input | 1 | 1 = store, 0 = fetch |
| addr_i | input | ADDR_W | Bus byte address |
| wdata_i | input | DATA_W | Store data |
| rdata_o | output | DATA_W | Fetch result, valid with ack_o |
| ack_o | output | 1 | Request acknowledged |
| power_o | output | 1 | Display on |
| level_o | output | LEVEL_W | Brightness level, 0 is dimmest |
| lights_o | output | LIGHT_N | Status light drives |

## Verification
The power word is stored with values whose only nonzero bits are high bits, with zero, and through each of its four byte addresses. These stores separate a full-width nonzero test from a low-bit test, and separate word decoding from exact-address decoding. Stores to the brightness and light words carry junk in their upper bits, which shows whether field masking is correct. Requests at base-1, base+11 and base+12, and requests with select low, probe both edges of the window. Random traffic mixes fetches and stores around the window and checks the acknowledge timing and the read data against a bench model.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  localparam int unsigned DCP_WIN_BYTES = 12;

  typedef enum logic [1:0] {
    FN_POWER  = 2'd0,
    FN_LEVEL  = 2'd1,
    FN_LIGHTS = 2'd2,
    FN_NONE   = 2'd3
  } dcp_fn_e;

  // word index within the window -> function
  function automatic dcp_fn_e fn_of_word(input logic [1:0] word);
    case (word)
      2'd0:    return FN_POWER;
      2'd1:    return FN_LEVEL;
      2'd2:    return FN_LIGHTS;
      default: return FN_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dcp_decode.sv
module dcp_decode
  import dcp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h100
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output dcp_fn_e           fn
);
  localparam logic [ADDR_W-1:0] WIN_LEN = ADDR_W'(DCP_WIN_BYTES);

  logic [ADDR_W-1:0] offset;
  logic              in_win;

  // unsigned wrap makes addresses below the base look huge
  assign offset = addr - BASE_ADDR;
  assign in_win = offset < WIN_LEN;
  assign hit    = sel & in_win;
  assign fn     = in_win ? fn_of_word(offset[3:2]) : FN_NONE;
endmodule

// File: rtl/dcp_regs.sv
module dcp_regs
  import dcp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEVEL_W = 4,
  parameter int LIGHT_N = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  dcp_fn_e            fn,
  input  logic [DATA_W-1:0]  wdata,
  output logic               power,
  output logic [LEVEL_W-1:0] level,
  output logic [LIGHT_N-1:0] lights
);
  logic wr_power, wr_level, wr_lights;

  assign wr_power  = wr_en && (fn == FN_POWER);
  assign wr_level  = wr_en && (fn == FN_LEVEL);
  assign wr_lights = wr_en && (fn == FN_LIGHTS);

  always_ff @(posedge clk) begin
    if (!rst_n)        power <= 1'b0;
    else if (wr_power) power <= |wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        level <= '0;
    else if (wr_level) level <= wdata[LEVEL_W-1:0];
  end

  for (genvar i = 0; i < LIGHT_N; i++) begin : g_light
    always_ff @(posedge clk) begin
      if (!rst_n)         lights[i] <= 1'b0;
      else if (wr_lights) lights[i] <= wdata[i];
    end
  end
endmodule

// File: rtl/dcp_resp.sv
module dcp_resp
  import dcp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              store,
  input  dcp_fn_e           fn,
  input  logic              power,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  logic rd_power;

  assign rd_power = hit && !store && (fn == FN_POWER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= hit;
      rdata <= rd_power ? {{(DATA_W-1){1'b0}}, power} : '0;
    end
  end
endmodule

// File: rtl/disp_ctl_periph.sv
module disp_ctl_periph
  import dcp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEVEL_W = 4,
  parameter int LIGHT_N = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               store_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               ack_o,
  output logic               power_o,
  output logic [LEVEL_W-1:0] level_o,
  output logic [LIGHT_N-1:0] lights_o
);
  logic    acc_hit;
  dcp_fn_e acc_fn;
  logic    acc_wr;

  dcp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .sel  (sel_i),
    .addr (addr_i),
    .hit  (acc_hit),
    .fn   (acc_fn)
  );

  assign acc_wr = acc_hit && store_i;

  dcp_regs #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .LIGHT_N(LIGHT_N)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (acc_wr),
    .fn     (acc_fn),
    .wdata  (wdata_i),
    .power  (power_o),
    .level  (level_o),
    .lights (lights_o)
  );

  dcp_resp #(.DATA_W(DATA_W)) u_resp (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (acc_hit),
    .store (store_i),
    .fn    (acc_fn),
    .power (power_o),
    .ack   (ack_o),
    .rdata (rdata_o)
  );
endmodule

// File: rtl/dcp_chk.sv
module dcp_chk
  import dcp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEVEL_W = 4,
  parameter int LIGHT_N = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               store_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               ack_o,
  input logic               power_o,
  input logic [LEVEL_W-1:0] level_o,
  input logic [LIGHT_N-1:0] lights_o,
  input logic               hit,
  input dcp_fn_e            fn
);
  // R7
  ack_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ack_o);

  // R7
  ack_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !ack_o);

  // R7
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> (rdata_o == '0));

  // R8
  no_stray_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(power_o) && $stable(level_o) && $stable(lights_o)));

  // R9
  fetch_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !store_i) |=> ($stable(power_o) && $stable(level_o) && $stable(lights_o)));

  // R2
  power_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && store_i && fn == FN_POWER) |=> (power_o == ($past(wdata_i) != '0)));

  // R3
  power_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !store_i && fn == FN_POWER) |=> (rdata_o == DATA_W'($past(power_o))));

  // R6
  quiet_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !store_i && fn != FN_POWER) |=> (rdata_o == '0));
endmodule

bind disp_ctl_periph dcp_chk #(
  .DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .LIGHT_N(LIGHT_N)
) u_dcp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .store_i  (store_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .ack_o    (ack_o),
  .power_o  (power_o),
  .level_o  (level_o),
  .lights_o (lights_o),
  .hit      (acc_hit),
  .fn       (acc_fn)
);

// File: tb/test_disp_ctl_periph.sv
module test_disp_ctl_periph;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_i = 1'b0;
  logic        store_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ack_o;
  logic        power_o;
  logic [3:0]  level_o;
  logic [15:0] lights_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        m_power  = 1'b0;
  logic [3:0]  m_level  = '0;
  logic [15:0] m_lights = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_ctl_periph #(.BASE_ADDR(BASE)) i_disp_ctl_periph (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .store_i(store_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o),
    .power_o(power_o), .level_o(level_o), .lights_o(lights_o)
  );

  function automatic bit in_window(input logic [31:0] a);
    return (a >= BASE) && (a <= BASE + 32'd11);
  endfunction

  function automatic int word_of(input logic [31:0] a);
    return int'((a - BASE) / 4);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit s, input bit st,
                        input logic [31:0] a, input logic [31:0] d);
    bit hit;
    int w;
    logic [31:0] exp_rd;
    string sreq;
    sel_i = s; store_i = st; addr_i = a; wdata_i = d;
    hit = s && in_window(a);
    w = hit ? word_of(a) : -1;
    exp_rd = (hit && !st && w == 0) ? {31'b0, m_power} : 32'b0;
    if (hit && st) begin
      if (w == 0) m_power  = (d != 0);
      if (w == 1) m_level  = d[3:0];
      if (w == 2) m_lights = d[15:0];
    end
    @(posedge clk);
    @(negedge clk);
    chk(hit ? "R7" : "R8", "ack", {31'b0, ack_o}, {31'b0, hit});
    chk((w == 0) ? "R3" : (hit ? "R6" : "R7"), "rdata", rdata_o, exp_rd);
    sreq = !hit ? "R8" : (!st ? "R9" : "R2");
    chk(sreq, "power", {31'b0, power_o}, {31'b0, m_power});
    sreq = !hit ? "R8" : (!st ? "R9" : "R4");
    chk(sreq, "level", {28'b0, level_o}, {28'b0, m_level});
    sreq = !hit ? "R8" : (!st ? "R9" : "R5");
    chk(sreq, "lights", {16'b0, lights_o}, {16'b0, m_lights});
  endtask

  task automatic idle();
    sel_i = 1'b0; store_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R7", "idle ack", {31'b0, ack_o}, 32'b0);
    chk("R7", "idle rdata", rdata_o, 32'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "power", {31'b0, power_o}, 32'b0);
    chk("R1", "level", {28'b0, level_o}, 32'b0);
    chk("R1", "lights", {16'b0, lights_o}, 32'b0);
    chk("R1", "ack", {31'b0, ack_o}, 32'b0);
    chk("R1", "rdata", rdata_o, 32'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 power word via each byte address
    access(1, 1, BASE + 1, 32'h5);
    access(1, 0, BASE + 3, 32'hDEAD);
    access(1, 1, BASE + 0, 32'h0);
    access(1, 0, BASE + 2, 32'h0);
    access(1, 1, BASE + 2, 32'h8000_0000);
    access(1, 0, BASE + 0, 32'h0);
    access(1, 1, BASE + 3, 32'h0001_0000);
    // R4 upper bits ignored
    access(1, 1, BASE + 4, 32'hFFFF_FFF9);
    access(1, 1, BASE + 7, 32'h0000_00F0);
    // R5 lights with junk above bit 15
    access(1, 1, BASE + 11, 32'hABCD_1234);
    access(1, 1, BASE + 8, 32'hFFFF_8001);
    // R6 quiet fetches, R9 no state change
    access(1, 0, BASE + 5, 32'hFFFF_FFFF);
    access(1, 0, BASE + 9, 32'hFFFF_FFFF);
    idle();
    // R8 window edges and deselected requests
    access(1, 1, BASE + 12, 32'h0);
    access(1, 1, BASE - 1, 32'h0);
    access(0, 1, BASE + 4, 32'h3);
    access(0, 1, BASE + 8, 32'h0);
    access(1, 0, BASE + 12, 32'h0);
    idle();

    // random traffic around the window
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      if ($urandom_range(0, 7) == 0) a = $urandom;
      else a = BASE - 32'd4 + 32'($urandom_range(0, 19));
      access($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
             ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom);
      if ($urandom_range(0, 5) == 0) idle();
    end
    idle();
    finish_run();
  end
endmodule